// File: doc/BRIEF.md
# Host Register Front-End with Posted-Write Interlock

This block sits between a host-side request decoder and the rest of a display controller. Each host request is either a register access or a memory-space access, and each one receives exactly one response: acknowledge (with read data) or retry. Writes to the mode registers go out over an 8-bit register bus, with a 6-bit select field, to the raster timing block. These writes are not stored here. A small set of general-purpose registers is kept locally, and a status word reports the raster retrace level and whether the write queue is empty.

Memory-space writes are posted into a 16-entry queue of address and data pairs, so a burst is acknowledged without stalling. A memory arbiter drains the queue through a valid/ready port. A memory-space read is forwarded as a held direct-read request. The reply data is returned to the host.

Every read is refused with retry while any posted write is still queued, so a read cannot overtake an earlier write. A forwarded read that gets no reply within the bounded window is aborted with retry, so the host is always answered inside 16 clocks. The host keeps at most one request outstanding and waits for its response before issuing the next one.

Top module: `host_reg_frontend`

## Requirements
- R1: After reset, rsp_valid, rast_wr, pw_valid and dr_req are all low.
- R2: A memory write (hst_mem=1, hst_we=1) that finds the queue not full is acknowledged (rsp_code 2'b01) in the cycle after the request edge. Queued writes leave on pw_addr/pw_data in arrival order, one per cycle in which pw_valid and pw_ready are both high.
- R3: A memory write that finds 16 entries queued is answered with retry (rsp_code 2'b10) and is discarded.
- R4: Any read, register or memory, that arrives while the queue holds an entry is answered with retry in the cycle after the request edge, and dr_req stays low.
- R5: A memory read that finds the queue empty raises dr_req with dr_addr equal to the host address, starting in the cycle after the request edge. If dr_ack is first sampled at clock edge k (1..15) after the request edge, the response is visible in the cycle after edge k, with code ack and rsp_rdata equal to dr_data, and dr_req drops.
- R6: If no reply has been sampled by edge 15, the read is answered with retry after edge 15 and dr_req drops. A reply that arrives later produces no response.
- R7: A register write to an address whose bits [7:6] are 2'b01 pulses rast_wr for one cycle, with rast_sel equal to address bits [5:0] and rast_data equal to write-data bits [7:0], and is acknowledged. Reads of that region return zero.
- R8: Register addresses 0x00 to 0x07 hold 32-bit values that are written and read back unchanged.
- R9: A register read of address 0x10 returns retrace in bit 0 (the value at the request edge), queue-empty in bit 1, and zero elsewhere. Writes to 0x10 have no effect.
- R10: Any other register address is acknowledged; reads return zero and writes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_req | input | 1 | Request strobe, one cycle |
| hst_we | input | 1 | 1 = write, 0 = read |
| hst_mem | input | 1 | 1 = memory space, 0 = register space |
| hst_addr | input | 32 | Request address (register space uses bits [7:0]) |
| hst_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe |
| rsp_code | output | 2 | 2'b01 acknowledge, 2'b10 retry |
| rsp_rdata | output | 32 | Read data with acknowledge |
| rast_wr | output | 1 | Raster register write strobe |
| rast_sel | output | 6 | Raster register select |
| rast_data | output | 8 | Raster register data |
| retrace | input | 1 | Retrace level from the raster block |
| pw_valid | output | 1 | Posted write available |
| pw_addr | output | 32 | Posted write address |
| pw_data | output | 32 | Posted write data |
| pw_ready | input | 1 | Arbiter takes the posted write |
| dr_req | output | 1 | Direct-read request, held until answered or aborted |
| dr_addr | output | 32 | Direct-read address |
| dr_ack | input | 1 | Direct-read reply strobe |
| dr_data | input | 32 | Direct-read reply data |

## Verification
A corrupted queue count or pointer shows up at the ports within one request: a retry appears where an acknowledge was due, a 17th write is accepted, a read is granted while writes remain, or pw_addr/pw_data come out in the wrong order on the first drained beat. An off-by-one in the read window shifts the latency of the acknowledged or aborted response by a cycle. Sweeping every reply edge from 1 to 16 exposes this on the first affected edge. A wrong register decode appears on the same request as a missing rast_wr pulse, wrong read-back data, or a status word with stray bits.

// File: rtl/regfe_pkg.sv
package regfe_pkg;
  typedef enum logic [1:0] {
    RSP_NONE  = 2'b00,
    RSP_ACK   = 2'b01,
    RSP_RETRY = 2'b10
  } rsp_e;

  localparam logic [1:0] RAST_TAG  = 2'b01;
  localparam logic [7:0] STAT_ADDR = 8'h10;
  localparam int         RSEL_W    = 6;
  localparam int         RDAT_W    = 8;
endpackage

// File: rtl/regfe_wfifo.sv
module regfe_wfifo #(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic          empty,
  output logic          full
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [AW-1:0] addr_mem [DEPTH];
  logic [DW-1:0] data_mem [DEPTH];
  logic [PW-1:0] wptr_q, wptr_n, rptr_q, rptr_n;
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    wptr_n = wptr_q;
    rptr_n = rptr_q;
    cnt_n  = cnt_q;
    if (push) wptr_n = wptr_q + 1'b1;
    if (pop)  rptr_n = rptr_q + 1'b1;
    if (push && !pop)      cnt_n = cnt_q + 1'b1;
    else if (pop && !push) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_n;
      rptr_q <= rptr_n;
      cnt_q  <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addr_mem[wptr_q] <= push_addr;
      data_mem[wptr_q] <= push_data;
    end
  end

  assign head_addr = addr_mem[rptr_q];
  assign head_data = data_mem[rptr_q];
  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == CW'(DEPTH));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q < CW'(DEPTH)));

  // R2
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0));
endmodule

// File: rtl/regfe_rdctl.sv
module regfe_rdctl
  import regfe_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int LIMIT = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  output logic          dr_req,
  output logic [AW-1:0] dr_addr,
  input  logic          dr_ack,
  input  logic [DW-1:0] dr_data,
  output logic          done,
  output rsp_e          done_code,
  output logic [DW-1:0] done_data
);
  localparam int CW = $clog2(LIMIT + 1);

  logic          busy_q, busy_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [AW-1:0] addr_q, addr_n;
  logic          done_q, done_n;
  rsp_e          code_q, code_n;
  logic [DW-1:0] data_q, data_n;

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    addr_n = addr_q;
    done_n = 1'b0;
    code_n = code_q;
    data_n = data_q;
    if (start) begin
      busy_n = 1'b1;
      cnt_n  = CW'(1);
      addr_n = start_addr;
    end else if (busy_q) begin
      if (dr_ack) begin
        busy_n = 1'b0;
        done_n = 1'b1;
        code_n = RSP_ACK;
        data_n = dr_data;
      end else if (cnt_q == CW'(LIMIT)) begin
        busy_n = 1'b0;
        done_n = 1'b1;
        code_n = RSP_RETRY;
        data_n = '0;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
      done_q <= 1'b0;
      code_q <= RSP_NONE;
      data_q <= '0;
    end else begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
      addr_q <= addr_n;
      done_q <= done_n;
      code_q <= code_n;
      data_q <= data_n;
    end
  end

  assign dr_req    = busy_q;
  assign dr_addr   = addr_q;
  assign done      = done_q;
  assign done_code = code_q;
  assign done_data = data_q;

  // R6
  rd_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q != '0 && cnt_q <= CW'(LIMIT)));

  // R5
  rd_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);
endmodule

// File: rtl/regfe_locregs.sv
module regfe_locregs #(
  parameter int NLOC = 8,
  parameter int DW   = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [$clog2(NLOC)-1:0] wr_idx,
  input  logic [DW-1:0]           wr_data,
  input  logic [$clog2(NLOC)-1:0] rd_idx,
  output logic [DW-1:0]           rd_data
);
  logic [DW-1:0] word_q [NLOC];

  for (genvar g = 0; g < NLOC; g++) begin : g_word
    logic sel;
    assign sel = wr_en && (wr_idx == g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q[g] <= '0;
      else if (sel) word_q[g] <= wr_data;
    end
  end

  assign rd_data = word_q[rd_idx];
endmodule

// File: rtl/host_reg_frontend.sv
module host_reg_frontend
  import regfe_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int WQ_DEPTH = 16,
  parameter int NLOC     = 8,
  parameter int RD_LIMIT = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hst_req,
  input  logic                hst_we,
  input  logic                hst_mem,
  input  logic [AW-1:0]       hst_addr,
  input  logic [DW-1:0]       hst_wdata,
  output logic                rsp_valid,
  output logic [1:0]          rsp_code,
  output logic [DW-1:0]       rsp_rdata,
  output logic                rast_wr,
  output logic [RSEL_W-1:0]   rast_sel,
  output logic [RDAT_W-1:0]   rast_data,
  input  logic                retrace,
  output logic                pw_valid,
  output logic [AW-1:0]       pw_addr,
  output logic [DW-1:0]       pw_data,
  input  logic                pw_ready,
  output logic                dr_req,
  output logic [AW-1:0]       dr_addr,
  input  logic                dr_ack,
  input  logic [DW-1:0]       dr_data
);
  localparam int LW = $clog2(NLOC);

  logic          q_empty, q_full, q_push, q_pop;
  logic          rd_start, rd_done;
  rsp_e          rd_code;
  logic [DW-1:0] rd_data, loc_rdata;
  logic [7:0]    reg_a;
  logic          is_read, reg_wr, rast_hit, loc_hit, stat_hit, refuse;

  logic                imm_vld_q, imm_vld_n;
  rsp_e                imm_code_q, imm_code_n;
  logic [DW-1:0]       imm_data_q, imm_data_n;
  logic                rwr_q, rwr_n;
  logic [RSEL_W-1:0]   rsel_q, rsel_n;
  logic [RDAT_W-1:0]   rdat_q, rdat_n;

  always_comb begin
    reg_a    = hst_addr[7:0];
    is_read  = hst_req && !hst_we;
    reg_wr   = hst_req && hst_we && !hst_mem;
    rast_hit = (reg_a[7:6] == RAST_TAG);
    loc_hit  = (int'(reg_a) < NLOC);
    stat_hit = (reg_a == STAT_ADDR);
    refuse   = (is_read && !q_empty) || (hst_req && hst_we && hst_mem && q_full);
    q_push   = hst_req && hst_we && hst_mem && !q_full;
    q_pop    = !q_empty && pw_ready;
    rd_start = is_read && hst_mem && q_empty;
  end

  always_comb begin
    imm_vld_n  = hst_req && !rd_start;
    imm_code_n = refuse ? RSP_RETRY : RSP_ACK;
    imm_data_n = '0;
    if (is_read && !hst_mem && !refuse) begin
      if (loc_hit)       imm_data_n = loc_rdata;
      else if (stat_hit) imm_data_n = {{(DW-2){1'b0}}, q_empty, retrace};
    end
    rwr_n  = reg_wr && rast_hit;
    rsel_n = rsel_q;
    rdat_n = rdat_q;
    if (rwr_n) begin
      rsel_n = reg_a[RSEL_W-1:0];
      rdat_n = hst_wdata[RDAT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imm_vld_q  <= 1'b0;
      imm_code_q <= RSP_NONE;
      imm_data_q <= '0;
      rwr_q      <= 1'b0;
      rsel_q     <= '0;
      rdat_q     <= '0;
    end else begin
      imm_vld_q  <= imm_vld_n;
      imm_code_q <= imm_code_n;
      imm_data_q <= imm_data_n;
      rwr_q      <= rwr_n;
      rsel_q     <= rsel_n;
      rdat_q     <= rdat_n;
    end
  end

  regfe_wfifo #(.DEPTH(WQ_DEPTH), .AW(AW), .DW(DW)) u_wq (
    .clk(clk), .rst_n(rst_n), .push(q_push), .push_addr(hst_addr),
    .push_data(hst_wdata), .pop(q_pop), .head_addr(pw_addr),
    .head_data(pw_data), .empty(q_empty), .full(q_full)
  );

  regfe_rdctl #(.AW(AW), .DW(DW), .LIMIT(RD_LIMIT)) u_rd (
    .clk(clk), .rst_n(rst_n), .start(rd_start), .start_addr(hst_addr),
    .dr_req(dr_req), .dr_addr(dr_addr), .dr_ack(dr_ack), .dr_data(dr_data),
    .done(rd_done), .done_code(rd_code), .done_data(rd_data)
  );

  regfe_locregs #(.NLOC(NLOC), .DW(DW)) u_loc (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr && loc_hit),
    .wr_idx(reg_a[LW-1:0]), .wr_data(hst_wdata),
    .rd_idx(reg_a[LW-1:0]), .rd_data(loc_rdata)
  );

  assign pw_valid  = !q_empty;
  assign rsp_valid = imm_vld_q || rd_done;
  assign rsp_code  = imm_vld_q ? imm_code_q : rd_code;
  assign rsp_rdata = imm_vld_q ? imm_data_q : rd_data;
  assign rast_wr   = rwr_q;
  assign rast_sel  = rsel_q;
  assign rast_data = rdat_q;

  // R4
  rd_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dr_req) |-> !pw_valid);

  // R5
  one_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(imm_vld_q && rd_done));

  // R7
  rast_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rast_wr |-> (rsp_valid && rsp_code == RSP_ACK));
endmodule

// File: tb/tb_host_reg_frontend.sv
module tb_host_reg_frontend;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_req = 1'b0, hst_we = 1'b0, hst_mem = 1'b0;
  logic [31:0] hst_addr = '0, hst_wdata = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_code;
  logic [31:0] rsp_rdata;
  logic        rast_wr;
  logic [5:0]  rast_sel;
  logic [7:0]  rast_data;
  logic        retrace = 1'b0;
  logic        pw_valid;
  logic [31:0] pw_addr, pw_data;
  logic        pw_ready = 1'b0;
  logic        dr_req;
  logic [31:0] dr_addr;
  logic        dr_ack = 1'b0;
  logic [31:0] dr_data = '0;

  int checks = 0;
  int errors = 0;
  logic [1:0]  got_code;
  logic [31:0] got_data;
  int          got_lat;

  localparam logic [1:0] ACK = 2'b01, RETRY = 2'b10;

  always #4 clk = ~clk;

  host_reg_frontend dut (
    .clk(clk), .rst_n(rst_n), .hst_req(hst_req), .hst_we(hst_we),
    .hst_mem(hst_mem), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_rdata(rsp_rdata),
    .rast_wr(rast_wr), .rast_sel(rast_sel), .rast_data(rast_data),
    .retrace(retrace), .pw_valid(pw_valid), .pw_addr(pw_addr),
    .pw_data(pw_data), .pw_ready(pw_ready), .dr_req(dr_req),
    .dr_addr(dr_addr), .dr_ack(dr_ack), .dr_data(dr_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_op(input bit we, input bit mem, input logic [31:0] a,
                         input logic [31:0] d);
    int n;
    @(negedge clk);
    hst_req = 1'b1; hst_we = we; hst_mem = mem; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_req = 1'b0;
    n = 0;
    while (!rsp_valid && n < 40) begin
      @(negedge clk);
      n++;
    end
    got_code = rsp_valid ? rsp_code : 2'b11;
    got_data = rsp_rdata;
    got_lat  = n;
  endtask

  task automatic mem_rd(input logic [31:0] a, input int k);
    int t;
    @(negedge clk);
    hst_req = 1'b1; hst_we = 1'b0; hst_mem = 1'b1; hst_addr = a;
    @(negedge clk);
    hst_req = 1'b0;
    chk(dr_req == 1'b1 && dr_addr == a, "R5 dr_req/dr_addr", dr_addr, a);
    t = 0;
    while (!rsp_valid && t < 40) begin
      if (t + 1 == k) begin
        dr_ack = 1'b1;
        dr_data = 32'hD000_0000 | 32'(k);
      end
      @(negedge clk);
      dr_ack = 1'b0;
      t++;
    end
    got_code = rsp_valid ? rsp_code : 2'b11;
    got_data = rsp_rdata;
    got_lat  = t;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!rsp_valid && !rast_wr && !pw_valid && !dr_req, "R1 reset outputs",
        {28'b0, rsp_valid, rast_wr, pw_valid, dr_req}, 32'h0);

    // R8 local registers: write all, read back all
    for (int i = 0; i < 8; i++) begin
      host_op(1'b1, 1'b0, 32'(i), 32'hA500_0000 ^ (32'(i) * 32'h0101_0101));
      chk(got_code == ACK && got_lat == 0, "R8 local write ack", 32'(got_code), 32'(ACK));
    end
    for (int i = 0; i < 8; i++) begin
      host_op(1'b0, 1'b0, 32'(i), 32'h0);
      chk(got_code == ACK && got_data == (32'hA500_0000 ^ (32'(i) * 32'h0101_0101)),
          "R8 local readback", got_data, 32'hA500_0000 ^ (32'(i) * 32'h0101_0101));
    end

    // R7 raster region: sweep all selects
    for (int s = 0; s < 64; s++) begin
      host_op(1'b1, 1'b0, 32'h40 + 32'(s), 32'hFFFF_FF00 | 32'((s * 3 + 7) & 8'hFF));
      chk(rast_wr && rast_sel == 6'(s) && rast_data == 8'((s * 3 + 7) & 8'hFF) && got_code == ACK,
          "R7 raster write", {rast_wr, 17'b0, rast_sel, rast_data},
          {1'b1, 17'b0, 6'(s), 8'((s * 3 + 7) & 8'hFF)});
    end
    @(negedge clk);
    chk(!rast_wr, "R7 raster strobe single cycle", 32'(rast_wr), 32'h0);
    host_op(1'b0, 1'b0, 32'h45, 32'h0);
    chk(got_code == ACK && got_data == 32'h0, "R7 raster read zero", got_data, 32'h0);

    // R9 status
    retrace = 1'b1;
    host_op(1'b0, 1'b0, 32'h10, 32'h0);
    chk(got_data == 32'h3, "R9 status retrace=1", got_data, 32'h3);
    retrace = 1'b0;
    host_op(1'b1, 1'b0, 32'h10, 32'hFFFF_FFFF);
    host_op(1'b0, 1'b0, 32'h10, 32'h0);
    chk(got_data == 32'h2, "R9 status retrace=0 after write", got_data, 32'h2);

    // R10 other register addresses
    host_op(1'b1, 1'b0, 32'h20, 32'h1234_5678);
    chk(got_code == ACK, "R10 other write ack", 32'(got_code), 32'(ACK));
    host_op(1'b0, 1'b0, 32'h20, 32'h0);
    chk(got_code == ACK && got_data == 32'h0, "R10 other read zero", got_data, 32'h0);
    host_op(1'b1, 1'b0, 32'hC3, 32'h5555_5555);
    host_op(1'b0, 1'b0, 32'hC3, 32'h0);
    chk(got_data == 32'h0, "R10 other read zero hi", got_data, 32'h0);
    host_op(1'b0, 1'b0, 32'h3, 32'h0);
    chk(got_data == (32'hA500_0000 ^ 32'h0303_0303), "R10 local untouched",
        got_data, 32'hA500_0000 ^ 32'h0303_0303);

    // R2/R3 fill the queue with arbiter stalled
    for (int i = 0; i < 16; i++) begin
      host_op(1'b1, 1'b1, 32'h1000_0000 + 32'(i) * 4, 32'(i) * 32'h1111_1111 ^ 32'h0F0F_0F0F);
      chk(got_code == ACK && got_lat == 0, "R2 posted write ack", 32'(got_code), 32'(ACK));
    end
    host_op(1'b1, 1'b1, 32'hDEAD_0000, 32'hDEAD_BEEF);
    chk(got_code == RETRY, "R3 full queue retry", 32'(got_code), 32'(RETRY));

    // R4 reads refused while queue non-empty
    host_op(1'b0, 1'b1, 32'h2000_0000, 32'h0);
    chk(got_code == RETRY && got_lat == 0 && !dr_req, "R4 mem read refused",
        32'(got_code), 32'(RETRY));
    host_op(1'b0, 1'b0, 32'h0, 32'h0);
    chk(got_code == RETRY, "R4 reg read refused", 32'(got_code), 32'(RETRY));
    host_op(1'b0, 1'b0, 32'h10, 32'h0);
    chk(got_code == RETRY, "R4 status read refused", 32'(got_code), 32'(RETRY));

    // R2 drain in order, R3 dropped entry absent
    @(negedge clk);
    pw_ready = 1'b1;
    for (int i = 0; i < 16; i++) begin
      chk(pw_valid && pw_addr == 32'h1000_0000 + 32'(i) * 4 &&
          pw_data == (32'(i) * 32'h1111_1111 ^ 32'h0F0F_0F0F),
          "R2 drain order", pw_data, 32'(i) * 32'h1111_1111 ^ 32'h0F0F_0F0F);
      @(negedge clk);
    end
    chk(!pw_valid, "R3 dropped write not queued", 32'(pw_valid), 32'h0);
    pw_ready = 1'b0;

    // R5 reply latency sweep
    for (int k = 1; k <= 15; k++) begin
      mem_rd(32'h3000_0000 + 32'(k), k);
      chk(got_code == ACK && got_lat == k && got_data == (32'hD000_0000 | 32'(k)),
          "R5 read reply", got_lat, k);
      chk(!dr_req, "R5 dr_req dropped", 32'(dr_req), 32'h0);
    end

    // R6 timeout and late reply
    mem_rd(32'h3FFF_0000, 16);
    chk(got_code == RETRY && got_lat == 15, "R6 timeout retry", got_lat, 15);
    chk(!dr_req, "R6 dr_req dropped", 32'(dr_req), 32'h0);
    dr_ack = 1'b1; dr_data = 32'hBAD0_BAD0;
    @(negedge clk);
    dr_ack = 1'b0;
    chk(!rsp_valid, "R6 late reply ignored", 32'(rsp_valid), 32'h0);
    mem_rd(32'h3FFF_0004, 0);
    chk(got_code == RETRY && got_lat == 15, "R6 no reply retry", got_lat, 15);

    // R4 read allowed again once drained; status shows empty
    host_op(1'b0, 1'b0, 32'h10, 32'h0);
    chk(got_code == ACK && got_data == 32'h2, "R9 status empty", got_data, 32'h2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule